// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is the engine of one DMA channel. It moves data between an I/O device and memory, one transfer per bus cycle slot. Software programs a start address, a transfer count, a mode word and a mask bit through a small register write port. A device then raises its request line. The channel asks a bus arbiter for ownership and, once granted, carries out transfers. On each transfer it presents the memory address, pulses the acknowledge line and drives the active-low memory strobes that match the transfer direction.

The address steps up or down after each transfer and the count steps down. When the count underflows, the terminal-count output marks the last transfer. The channel then either reloads its working registers from the programmed base values or masks itself. Memory strobes are qualified by address range so that a narrow legacy memory bus never sees an aliased access. The general strobe is limited to the low 16 MB and the system strobe to the low 1 MB. A cascade setting turns the channel into a pass-through that lets a downstream requester own the bus without the channel moving any data.

Top module: `dma_chan_seq`

## Requirements
- R1: After synchronous reset the channel is masked. `hreq`, `dack` and `tc` are low, all four strobes are high and `mem_addr` is zero. A request on `dreq` raises no bus request until the mask is cleared.
- R2: A write with `cfg_sel`=0 loads both the base and the current address. `cfg_sel`=1 loads both the base and the current count (low CNT_W bits). `cfg_sel`=2 writes the mode word. `cfg_sel`=3 writes the mask from bit 0 (1 = masked). The next transfer uses the written address.
- R3: Mode word bits [1:0] select the type: 0 verify, 1 write (memory written), 2 read (memory read), 3 memory-to-memory. A write carrying type 3 is dropped whole and the previous mode stays in force. Bits [3:2] select the operation: 0 demand, 1 single, 2 block, 3 cascade. Bit 4 enables auto-reload. Bit 5 makes the address count downward.
- R4: Every transfer moves the current address by one (up, or down when bit 5 is set) and decrements the current count. A programmed count N yields N+1 transfers.
- R5: A read transfer drives `memr_n` low and a write transfer drives `memw_n` low. A verify transfer drives no strobe. Any strobe is low only in a cycle where `dack` is high.
- R6: `memr_n`/`memw_n` go low only when `mem_addr` is below 0x1000000. `smemr_n`/`smemw_n` go low, together with the matching general strobe, only when `mem_addr` is below 0x0100000. From 0x1000000 upward no strobe is driven at all.
- R7: `tc` is high for exactly the `dack` cycle of the transfer made with count zero.
- R8: With auto-reload set, the transfer that reaches terminal count reloads the current address and count from the base registers. The channel keeps running from the base address.
- R9: With auto-reload clear, terminal count sets the mask. No further request is made while `dreq` stays high.
- R10: In single operation `hreq` drops after every transfer. Two `dack` pulses are never in adjacent cycles.
- R11: In block operation the transfers follow in consecutive cycles until terminal count, whatever `dreq` does after the first.
- R12: In demand operation `dreq` is sampled in each transfer cycle, which is the cycle before its `dack`. If it is low there, that transfer ends the burst and `hreq` drops.
- R13: In cascade operation `hreq` follows unmasked `dreq` one cycle later and `dack` mirrors `hgrant` while `dreq` is high. No strobe or `tc` is produced and the address does not move.
- R14: `hreq` rises one cycle after an unmasked `dreq`. Transfers start only after `hgrant` is seen high. The `dack` of a transfer follows a cycle in which `hgrant` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 address, 1 count, 2 mode, 3 mask) |
| cfg_wdata | input | ADDR_W | Register write data |
| dreq | input | 1 | Device request, active high, synchronous |
| hgrant | input | 1 | Bus grant from the arbiter |
| hreq | output | 1 | Bus request to the arbiter |
| dack | output | 1 | Device acknowledge, one cycle per transfer |
| tc | output | 1 | Terminal count, with the last transfer's acknowledge |
| mem_addr | output | ADDR_W | Memory address of the current transfer |
| memr_n | output | 1 | Memory read strobe, below 16 MB, active low |
| memw_n | output | 1 | Memory write strobe, below 16 MB, active low |
| smemr_n | output | 1 | System memory read strobe, below 1 MB, active low |
| smemw_n | output | 1 | System memory write strobe, below 1 MB, active low |

## Verification
The checker assumes three things about the inputs. `dreq` is already synchronous to `clk`. The arbiter keeps `hgrant` high for as long as `hreq` stays high. The mode word is not rewritten while a burst is in flight. The bench uses an arbiter model that registers `hreq` into `hgrant`, behind an enable that can hold the grant off. It changes inputs only on falling edges and writes configuration only while the channel is idle or masked. A demand-mode device drops its request in reaction to the acknowledges it has seen.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    XF_VERIFY  = 2'd0,
    XF_WRITE   = 2'd1,
    XF_READ    = 2'd2,
    XF_MEM2MEM = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    OP_DEMAND  = 2'd0,
    OP_SINGLE  = 2'd1,
    OP_BLOCK   = 2'd2,
    OP_CASCADE = 2'd3
  } op_e;

  typedef struct packed {
    logic  addr_down;
    logic  auto_init;
    op_e   op;
    xfer_e xfer;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_MODE  = 2'd2;
  localparam logic [1:0] SEL_MASK  = 2'd3;

  typedef struct packed {
    logic memr;
    logic memw;
    logic smemr;
    logic smemw;
  } strobe_t;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output mode_t             mode,
  output logic              masked,
  output logic              last
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  base_count;
  logic [CNT_W-1:0]  cur_count;
  logic [ADDR_W-1:0] addr_next;
  logic              mode_ok;

  assign last    = (cur_count == '0);
  assign mode_ok = (wr_data[1:0] != XF_MEM2MEM);

  generate
    if (ADDR_W > 1) begin : g_step
      always_comb begin
        if (mode.addr_down) addr_next = cur_addr - ADDR_ONE;
        else                addr_next = cur_addr + ADDR_ONE;
      end
    end else begin : g_step_bit
      always_comb addr_next = ~cur_addr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr  <= '0;
      base_count <= '0;
      cur_addr   <= '0;
      cur_count  <= '0;
      mode       <= '0;
      masked     <= 1'b1;
    end else begin
      if (step) begin
        if (last) begin
          if (mode.auto_init) begin
            cur_addr  <= base_addr;
            cur_count <= base_count;
          end else begin
            cur_addr  <= addr_next;
            cur_count <= cur_count - CNT_ONE;
            masked    <= 1'b1;
          end
        end else begin
          cur_addr  <= addr_next;
          cur_count <= cur_count - CNT_ONE;
        end
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_ADDR: begin
            base_addr <= wr_data;
            cur_addr  <= wr_data;
          end
          SEL_COUNT: begin
            base_count <= wr_data[CNT_W-1:0];
            cur_count  <= wr_data[CNT_W-1:0];
          end
          SEL_MODE: begin
            if (mode_ok) mode <= mode_t'(wr_data[MODE_W-1:0]);
          end
          default: masked <= wr_data[0];
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dreq,
  input  logic hgrant,
  input  logic masked,
  input  op_e  op,
  input  logic last,
  output logic hreq,
  output logic fire
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2
  } st_e;

  st_e  st_q, st_d;
  logic casc;

  assign casc = (op == OP_CASCADE);
  assign fire = (st_q == ST_OWN) && !casc;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (!masked && dreq && !casc) st_d = ST_WAIT;
      ST_WAIT: begin
        if (casc || masked) st_d = ST_IDLE;
        else if (hgrant)    st_d = ST_OWN;
      end
      ST_OWN: begin
        if (casc || last) st_d = ST_IDLE;
        else begin
          case (op)
            OP_BLOCK:  st_d = ST_OWN;
            OP_DEMAND: st_d = dreq ? ST_OWN : ST_IDLE;
            default:   st_d = ST_IDLE;
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      hreq <= 1'b0;
    end else begin
      st_q <= st_d;
      if (casc) hreq <= dreq && !masked;
      else      hreq <= (st_d != ST_IDLE);
    end
  end

endmodule

// File: rtl/dma_strobe_dec.sv
module dma_strobe_dec
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W    = 27,
  parameter int FULL_BITS = 24,
  parameter int SYS_BITS  = 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  xfer_e             xfer,
  input  logic              en,
  output strobe_t           stb
);

  logic in_full;
  logic in_sys;
  logic rd;
  logic wr;

  generate
    if (FULL_BITS >= ADDR_W) begin : g_full_all
      assign in_full = 1'b1;
    end else begin : g_full_cmp
      assign in_full = (addr[ADDR_W-1:FULL_BITS] == '0);
    end
    if (SYS_BITS >= ADDR_W) begin : g_sys_all
      assign in_sys = 1'b1;
    end else begin : g_sys_cmp
      assign in_sys = (addr[ADDR_W-1:SYS_BITS] == '0);
    end
  endgenerate

  assign rd = en && (xfer == XF_READ);
  assign wr = en && (xfer == XF_WRITE);

  always_comb begin
    stb.memr  = rd && in_full;
    stb.memw  = wr && in_full;
    stb.smemr = rd && in_full && in_sys;
    stb.smemw = wr && in_full && in_sys;
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W    = 27,
  parameter int CNT_W     = 16,
  parameter int FULL_BITS = 24,
  parameter int SYS_BITS  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              dreq,
  input  logic              hgrant,
  output logic              hreq,
  output logic              dack,
  output logic              tc,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              memr_n,
  output logic              memw_n,
  output logic              smemr_n,
  output logic              smemw_n
);

  logic [ADDR_W-1:0] cur_addr;
  mode_t             mode_q;
  logic              masked;
  logic              last;
  logic              fire;
  logic              casc;
  strobe_t           stb;

  assign casc = (mode_q.op == OP_CASCADE);

  dma_chan_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_sel   (cfg_sel),
    .wr_data  (cfg_wdata),
    .step     (fire),
    .cur_addr (cur_addr),
    .mode     (mode_q),
    .masked   (masked),
    .last     (last)
  );

  dma_chan_ctl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .dreq   (dreq),
    .hgrant (hgrant),
    .masked (masked),
    .op     (mode_q.op),
    .last   (last),
    .hreq   (hreq),
    .fire   (fire)
  );

  dma_strobe_dec #(
    .ADDR_W    (ADDR_W),
    .FULL_BITS (FULL_BITS),
    .SYS_BITS  (SYS_BITS)
  ) u_dec (
    .addr (cur_addr),
    .xfer (mode_q.xfer),
    .en   (fire),
    .stb  (stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dack     <= 1'b0;
      tc       <= 1'b0;
      mem_addr <= '0;
      memr_n   <= 1'b1;
      memw_n   <= 1'b1;
      smemr_n  <= 1'b1;
      smemw_n  <= 1'b1;
    end else begin
      dack    <= fire || (casc && hgrant && dreq && !masked);
      tc      <= fire && last;
      memr_n  <= !stb.memr;
      memw_n  <= !stb.memw;
      smemr_n <= !stb.smemr;
      smemw_n <= !stb.smemw;
      if (fire) mem_addr <= cur_addr;
    end
  end

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W    = 27,
  parameter int FULL_BITS = 24,
  parameter int SYS_BITS  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              hgrant,
  input logic              dack,
  input logic              tc,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              memr_n,
  input logic              memw_n,
  input logic              smemr_n,
  input logic              smemw_n,
  input op_e               op,
  input logic              auto_init,
  input logic              masked
);

  logic any_stb;
  assign any_stb = !memr_n || !memw_n || !smemr_n || !smemw_n;

  assert_strobe_in_ack_R5: assert property (@(posedge clk) disable iff (rst)
    any_stb |-> dack);

  assert_one_direction_R5: assert property (@(posedge clk) disable iff (rst)
    (!memr_n || !smemr_n) |-> (memw_n && smemw_n));

  assert_no_alias_R6: assert property (@(posedge clk) disable iff (rst)
    (!memr_n || !memw_n) |-> (mem_addr[ADDR_W-1:FULL_BITS] == '0));

  assert_sys_low_meg_R6: assert property (@(posedge clk) disable iff (rst)
    (!smemr_n || !smemw_n) |-> (mem_addr[ADDR_W-1:SYS_BITS] == '0));

  assert_sys_read_pairs_R6: assert property (@(posedge clk) disable iff (rst)
    !smemr_n |-> !memr_n);

  assert_sys_write_pairs_R6: assert property (@(posedge clk) disable iff (rst)
    !smemw_n |-> !memw_n);

  assert_tc_with_ack_R7: assert property (@(posedge clk) disable iff (rst)
    tc |-> dack);

  assert_tc_masks_R9: assert property (@(posedge clk) disable iff (rst)
    (tc && !$past(auto_init) && !$past(cfg_we)) |-> masked);

  assert_single_gap_R10: assert property (@(posedge clk) disable iff (rst)
    (dack && $past(op) == OP_SINGLE) |=> !dack);

  assert_cascade_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    ($past(op) == OP_CASCADE) |-> (!any_stb && !tc));

  assert_ack_after_grant_R14: assert property (@(posedge clk) disable iff (rst)
    dack |-> $past(hgrant));

endmodule

bind dma_chan_seq dma_chan_seq_chk #(
  .ADDR_W    (ADDR_W),
  .FULL_BITS (FULL_BITS),
  .SYS_BITS  (SYS_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .hgrant    (hgrant),
  .dack      (dack),
  .tc        (tc),
  .mem_addr  (mem_addr),
  .memr_n    (memr_n),
  .memw_n    (memw_n),
  .smemr_n   (smemr_n),
  .smemw_n   (smemw_n),
  .op        (mode_q.op),
  .auto_init (mode_q.auto_init),
  .masked    (masked)
);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 27;
  localparam int MAXREC = 64;

  localparam logic [1:0] T_VER = 2'd0, T_WR = 2'd1, T_RD = 2'd2, T_M2M = 2'd3;
  localparam logic [1:0] O_DEM = 2'd0, O_SGL = 2'd1, O_BLK = 2'd2, O_CAS = 2'd3;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic          dreq;
  logic          hgrant;
  logic          hreq, dack, tc;
  logic [AW-1:0] mem_addr;
  logic          memr_n, memw_n, smemr_n, smemw_n;
  logic          grant_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int stray = 0;
  int n_rec = 0;
  bit done = 0;

  logic [AW-1:0] r_addr [MAXREC];
  bit            r_mr   [MAXREC];
  bit            r_mw   [MAXREC];
  bit            r_sr   [MAXREC];
  bit            r_sw   [MAXREC];
  bit            r_tc   [MAXREC];
  int            r_cyc  [MAXREC];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dreq(dreq), .hgrant(hgrant), .hreq(hreq), .dack(dack), .tc(tc),
    .mem_addr(mem_addr), .memr_n(memr_n), .memw_n(memw_n),
    .smemr_n(smemr_n), .smemw_n(smemw_n)
  );

  // arbiter model: grant follows request one cycle later
  always_ff @(posedge clk) begin
    if (rst) hgrant <= 1'b0;
    else     hgrant <= hreq && grant_en;
  end

  // transfer recorder
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if ((!memr_n || !memw_n || !smemr_n || !smemw_n) && !dack) stray = stray + 1;
      if (dack && n_rec < MAXREC) begin
        r_addr[n_rec] = mem_addr;
        r_mr[n_rec]   = !memr_n;
        r_mw[n_rec]   = !memw_n;
        r_sr[n_rec]   = !smemr_n;
        r_sw[n_rec]   = !smemw_n;
        r_tc[n_rec]   = tc;
        r_cyc[n_rec]  = cyc;
        n_rec = n_rec + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [AW-1:0] md(input bit dn, input bit ai,
                                       input logic [1:0] op, input logic [1:0] xf);
    return AW'({dn, ai, op, xf});
  endfunction

  task automatic launch(input logic [AW-1:0] base, input logic [15:0] cnt,
                        input logic [AW-1:0] mw, input bit wmode, input int drop_after);
    cfg(2'd0, base);
    cfg(2'd1, AW'(cnt));
    if (wmode) cfg(2'd2, mw);
    cfg(2'd3, '0);
    n_rec = 0;
    dreq = 1'b1;
    for (int i = 0; i < 60 && n_rec < drop_after; i++) begin
      @(negedge clk); #1;
    end
    dreq = 1'b0;
    repeat (25) @(negedge clk);
  endtask

  task automatic t_reset;
    bit saw;
    chk(hreq == 0, "R1", "hreq after reset", hreq, 0);
    chk(dack == 0 && tc == 0, "R1", "dack/tc after reset", {dack, tc}, 0);
    chk({memr_n, memw_n, smemr_n, smemw_n} == 4'hf, "R1", "strobes after reset",
        {memr_n, memw_n, smemr_n, smemw_n}, 4'hf);
    chk(mem_addr == 0, "R1", "address after reset", mem_addr, 0);
    saw = 0;
    dreq = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #1;
      if (hreq) saw = 1;
    end
    dreq = 1'b0;
    chk(!saw, "R1", "masked channel requested bus", saw, 0);
  endtask

  task automatic t_single_read;
    launch(27'h0001000, 16'd2, md(0, 0, O_SGL, T_RD), 1, 99);
    chk(n_rec == 3, "R4", "transfer count for N=2", n_rec, 3);
    for (int i = 0; i < 3 && i < n_rec; i++) begin
      chk(r_addr[i] == 27'h0001000 + i, "R2", "incrementing address", r_addr[i], 27'h0001000 + i);
      chk(r_mr[i] && r_sr[i] && !r_mw[i] && !r_sw[i], "R5", "read strobes",
          {r_mr[i], r_sr[i], r_mw[i], r_sw[i]}, 4'b1100);
      chk(r_tc[i] == (i == 2), "R7", "terminal count position", r_tc[i], (i == 2));
      if (i > 0) chk(r_cyc[i] - r_cyc[i-1] > 1, "R10", "single mode gap", r_cyc[i] - r_cyc[i-1], 2);
    end
    chk(hreq == 0, "R9", "request after terminal count", hreq, 0);
  endtask

  task automatic t_block_write_down;
    launch(27'h0200005, 16'd3, md(1, 0, O_BLK, T_WR), 1, 1);
    chk(n_rec == 4, "R11", "block burst length", n_rec, 4);
    for (int i = 0; i < 4 && i < n_rec; i++) begin
      chk(r_addr[i] == 27'h0200005 - i, "R4", "decrementing address", r_addr[i], 27'h0200005 - i);
      chk(r_mw[i] && !r_sw[i] && !r_mr[i], "R6", "write above 1MB: general only",
          {r_mw[i], r_sw[i], r_mr[i]}, 3'b100);
      chk(r_cyc[i] == r_cyc[0] + i, "R11", "back-to-back cycles", r_cyc[i], r_cyc[0] + i);
    end
    if (n_rec == 4) chk(r_tc[3], "R7", "tc on last block transfer", r_tc[3], 1);
  endtask

  task automatic t_alias_region;
    launch(27'h1000000, 16'd1, md(0, 0, O_BLK, T_RD), 1, 1);
    chk(n_rec == 2, "R6", "transfers above 16MB still run", n_rec, 2);
    for (int i = 0; i < 2 && i < n_rec; i++)
      chk(!r_mr[i] && !r_sr[i] && !r_mw[i] && !r_sw[i], "R6", "no strobe above 16MB",
          {r_mr[i], r_sr[i], r_mw[i], r_sw[i]}, 0);
  endtask

  task automatic t_meg_edge;
    launch(27'h00FFFFF, 16'd1, md(0, 0, O_BLK, T_RD), 1, 1);
    chk(n_rec == 2, "R6", "1MB edge burst", n_rec, 2);
    if (n_rec == 2) begin
      chk(r_mr[0] && r_sr[0], "R6", "both read strobes just below 1MB", {r_mr[0], r_sr[0]}, 2'b11);
      chk(r_addr[1] == 27'h0100000, "R4", "crossed 1MB", r_addr[1], 27'h0100000);
      chk(r_mr[1] && !r_sr[1], "R6", "general only at 1MB", {r_mr[1], r_sr[1]}, 2'b10);
    end
  endtask

  task automatic t_sixteen_edge;
    launch(27'h0FFFFFF, 16'd1, md(0, 0, O_BLK, T_WR), 1, 1);
    chk(n_rec == 2, "R6", "16MB edge burst", n_rec, 2);
    if (n_rec == 2) begin
      chk(r_mw[0] && !r_sw[0], "R6", "general write just below 16MB", {r_mw[0], r_sw[0]}, 2'b10);
      chk(!r_mw[1] && !r_sw[1], "R6", "no write strobe at 16MB", {r_mw[1], r_sw[1]}, 0);
    end
  endtask

  task automatic t_verify;
    launch(27'h0002000, 16'd2, md(0, 0, O_SGL, T_VER), 1, 99);
    chk(n_rec == 3, "R5", "verify transfers acknowledged", n_rec, 3);
    for (int i = 0; i < 3 && i < n_rec; i++)
      chk(!r_mr[i] && !r_mw[i] && !r_sr[i] && !r_sw[i], "R5", "verify drives no strobe",
          {r_mr[i], r_mw[i], r_sr[i], r_sw[i]}, 0);
  endtask

  task automatic t_autoinit;
    launch(27'h0000300, 16'd1, md(0, 1, O_SGL, T_RD), 1, 6);
    chk(n_rec >= 6, "R8", "channel keeps running", n_rec, 6);
    for (int i = 0; i < 6 && i < n_rec; i++) begin
      chk(r_addr[i] == 27'h0000300 + (i % 2), "R8", "reloaded address", r_addr[i], 27'h0000300 + (i % 2));
      chk(r_tc[i] == (i % 2 == 1), "R8", "tc every second transfer", r_tc[i], (i % 2 == 1));
    end
    cfg(2'd3, AW'(1));
    repeat (5) @(negedge clk);
  endtask

  task automatic t_demand;
    launch(27'h0000400, 16'd20, md(0, 0, O_DEM, T_RD), 1, 3);
    chk(n_rec == 4, "R12", "demand burst ends after request drop", n_rec, 4);
    for (int i = 1; i < 4 && i < n_rec; i++)
      chk(r_cyc[i] == r_cyc[0] + i, "R12", "demand back-to-back", r_cyc[i], r_cyc[0] + i);
    chk(hreq == 0, "R12", "bus released", hreq, 0);
    if (n_rec == 4) chk(!r_tc[3], "R12", "no tc mid-count", r_tc[3], 0);
    cfg(2'd3, AW'(1));
  endtask

  task automatic t_reject;
    cfg(2'd2, md(0, 0, O_SGL, T_RD));
    cfg(2'd2, md(0, 0, O_BLK, T_M2M));
    launch(27'h0000500, 16'd1, '0, 0, 99);
    chk(n_rec == 2, "R3", "rejected mode: transfers", n_rec, 2);
    if (n_rec == 2) begin
      chk(r_mr[0] && r_mr[1], "R3", "previous read type kept", {r_mr[0], r_mr[1]}, 2'b11);
      chk(r_cyc[1] - r_cyc[0] > 1, "R3", "previous single op kept", r_cyc[1] - r_cyc[0], 2);
    end
  endtask

  task automatic t_cascade;
    bit any_tc;
    bit any_stb;
    cfg(2'd2, md(0, 0, O_CAS, T_RD));
    cfg(2'd3, '0);
    n_rec = 0;
    dreq = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    chk(hreq == 1, "R13", "cascade passes request", hreq, 1);
    chk(dack == 1, "R13", "cascade passes grant", dack, 1);
    dreq = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(hreq == 0 && dack == 0, "R13", "cascade released", {hreq, dack}, 0);
    any_tc = 0; any_stb = 0;
    for (int i = 0; i < n_rec; i++) begin
      if (r_tc[i]) any_tc = 1;
      if (r_mr[i] || r_mw[i] || r_sr[i] || r_sw[i]) any_stb = 1;
    end
    chk(n_rec > 0 && !any_tc && !any_stb, "R13", "cascade moved no data",
        {any_tc, any_stb}, 0);
    chk(mem_addr == 27'h0000501, "R13", "address untouched in cascade", mem_addr, 27'h0000501);
    cfg(2'd3, AW'(1));
  endtask

  task automatic t_handshake;
    grant_en = 1'b0;
    cfg(2'd0, 27'h0000600);
    cfg(2'd1, '0);
    cfg(2'd2, md(0, 0, O_SGL, T_RD));
    cfg(2'd3, '0);
    n_rec = 0;
    dreq = 1'b1;
    @(negedge clk); #1;
    chk(hreq == 1, "R14", "request one cycle after dreq", hreq, 1);
    repeat (20) @(negedge clk);
    #1;
    chk(n_rec == 0, "R14", "no transfer without grant", n_rec, 0);
    grant_en = 1'b1;
    repeat (20) @(negedge clk);
    dreq = 1'b0;
    chk(n_rec == 1, "R14", "one transfer once granted", n_rec, 1);
    if (n_rec == 1) begin
      chk(r_tc[0], "R7", "count zero gives tc on first transfer", r_tc[0], 1);
      chk(r_addr[0] == 27'h0000600, "R2", "programmed address used", r_addr[0], 27'h0000600);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; dreq = 1'b0; grant_en = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    t_reset;
    t_single_read;
    t_block_write_down;
    t_alias_region;
    t_meg_edge;
    t_sixteen_edge;
    t_verify;
    t_autoinit;
    t_demand;
    t_reject;
    t_cascade;
    t_handshake;
    chk(stray == 0, "R5", "strobe outside acknowledge", stray, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule